// File: doc/BRIEF.md
# Registered narrow-to-wide bus exchanger

This block joins a 12-bit narrow port A to a 24-bit wide port built from two 12-bit halves, called 1B and 2B. Going from narrow to wide, it gathers two narrow words that arrive one after the other and presents them together on the wide port. The 1B half passes through two register stages and the 2B half through one. The second 1B stage advances on the same enable that loads 2B, so a word taken first lands on 1B in the same cycle as the word taken second lands on 2B.

Going from wide to narrow, the 1B and 2B halves are captured into two separate registers, and a registered select decides which of them drives A. Every port models its tri-state pad as three separate signals: data-out, output-enable and data-in. Which ports drive is set by two active-low drive requests, and both requests are registered on the clock.

A synchronous active-high reset clears every data register to zero and turns all drivers off. A port never captures its own input while it is driving, so the block cannot read back data it is sending out.

Top module: `nwx_exchanger`

## Requirements
- R1: After a synchronous reset, `b1_out`, `b2_out` and `a_out` read 0 and both `a_oe` and `b_oe` read 0.
- R2: At an edge where `ld_1b_n`=0, `ld_2b_n`=1 and A is not driving, `a_in` enters the first 1B stage, and `b1_out` and `b2_out` keep their values.
- R3: At an edge where `ld_2b_n`=0 and A is not driving, `b2_out` takes `a_in`, and `b1_out` takes the value held in the first 1B stage before that edge.
- R4: With both load enables low, a word on `a_in` reaches `b2_out` after one edge and reaches `b1_out` after two edges.
- R5: With both load enables high, `b1_out` and `b2_out` hold their values on every edge.
- R6: Presenting word X with (`ld_1b_n`,`ld_2b_n`)=(0,1) and then word Y with (1,0) leaves `b1_out`=X and `b2_out`=Y at the same time.
- R7: The 1B-to-A and 2B-to-A registers capture `b1_in` and `b2_in` on edges where `cap_1b_n` or `cap_2b_n` (respectively) is low. Each register keeps its value while its enable is high.
- R8: `ret_sel` is sampled on the edge. After an edge with `ret_sel`=1, `a_out` shows the 1B-to-A register; after an edge with `ret_sel`=0, it shows the 2B-to-A register.
- R9: After each edge, `a_oe` equals the inverse of the `a_drv_n` sampled at that edge, and `b_oe` equals the inverse of the sampled `b_drv_n`. The four cases are: (1,1) no port drives, (0,1) only A drives, (1,0) only the B ports drive, (0,0) all ports drive.
- R10: While `a_oe`=1, the narrow-to-wide registers ignore `a_in`. While `b_oe`=1, the wide-to-narrow registers ignore `b1_in` and `b2_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Data seen on the narrow pad |
| a_out | output | 12 | Data the narrow pad drives |
| a_oe | output | 1 | Narrow pad drive enable |
| b1_in | input | 12 | Data seen on the 1B pad |
| b1_out | output | 12 | Data the 1B pad drives |
| b2_in | input | 12 | Data seen on the 2B pad |
| b2_out | output | 12 | Data the 2B pad drives |
| b_oe | output | 1 | Drive enable shared by 1B and 2B |
| ld_1b_n | input | 1 | Active-low load of the first 1B stage |
| ld_2b_n | input | 1 | Active-low load of 2B and of the second 1B stage |
| cap_1b_n | input | 1 | Active-low capture of the 1B-to-A register |
| cap_2b_n | input | 1 | Active-low capture of the 2B-to-A register |
| ret_sel | input | 1 | Return select: 1 picks 1B, 0 picks 2B |
| a_drv_n | input | 1 | Active-low request for A to drive |
| b_drv_n | input | 1 | Active-low request for the B ports to drive |

## Verification
Each load-enable combination is applied on its own to a few fixed words. This separates the first-stage-only load, the 2B-only load, the both-low case with its one-edge and two-edge latencies, and the hold case. A stream of random word pairs with alternating enables tests the alignment on the wide port, which fails if the second 1B stage advances at the wrong time. On the return path, the capture enables are toggled one at a time against different select values, which tells a wrong register choice apart from a missed capture. All four drive combinations are then used with data present on the inputs, to show that a driving port ignores its own input. A long run of random stimulus is also compared with a model built from the requirements.

// File: rtl/nwx_pkg.sv
package nwx_pkg;
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2,
        DRV_ALL  = 2'd3
    } drv_mode_e;

    function automatic drv_mode_e decode_drv(input logic a_n, input logic b_n);
        case ({a_n, b_n})
            2'b11:   return DRV_NONE;
            2'b01:   return DRV_A;
            2'b10:   return DRV_B;
            default: return DRV_ALL;
        endcase
    endfunction
endpackage

// File: rtl/nwx_a2b_path.sv
module nwx_a2b_path #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         blk,
    input  logic         ld_1b_n,
    input  logic         ld_2b_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] b1_out,
    output logic [W-1:0] b2_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
        logic [W-1:0] wide2;
    } a2b_t;

    a2b_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!blk) begin
            if (!ld_1b_n) st_d.stage1 = a_in;
            if (!ld_2b_n) begin
                st_d.stage2 = st_q.stage1;
                st_d.wide2  = a_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign b1_out = st_q.stage2;
    assign b2_out = st_q.wide2;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ld_1b_n && ld_2b_n) |=> ($stable(b1_out) && $stable(b2_out))); // R5
    AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!ld_1b_n && ld_2b_n) |=> ($stable(b1_out) && $stable(b2_out))); // R2
    AST_WIDE2_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!blk && !ld_2b_n) |=> (b2_out == $past(a_in))); // R3
endmodule

// File: rtl/nwx_b2a_path.sv
module nwx_b2a_path #(
    parameter int W     = 12,
    parameter int LANES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       blk,
    input  logic [LANES-1:0]           cap_n,
    input  logic [LANES-1:0][W-1:0]    b_in,
    output logic [LANES-1:0][W-1:0]    ret_q
);
    typedef struct packed {
        logic [LANES-1:0][W-1:0] lane;
    } b2a_t;

    b2a_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LANES; i++) begin
            if (!blk && !cap_n[i]) st_d.lane[i] = b_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ret_q = st_q.lane;

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
            (cap_n[g] || blk) |=> $stable(ret_q[g])); // R7
        AST_LANE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            (!cap_n[g] && !blk) |=> (ret_q[g] == $past(b_in[g]))); // R7
    end
endmodule

// File: rtl/nwx_oe_ctrl.sv
module nwx_oe_ctrl
    import nwx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_drv_n,
    input  logic b_drv_n,
    input  logic ret_sel,
    output logic a_oe,
    output logic b_oe,
    output logic sel_q
);
    typedef struct packed {
        drv_mode_e mode;
        logic      sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mode = decode_drv(a_drv_n, b_drv_n);
        ctl_d.sel  = ret_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.mode <= DRV_NONE;
            ctl_q.sel  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign a_oe  = (ctl_q.mode == DRV_A) || (ctl_q.mode == DRV_ALL);
    assign b_oe  = (ctl_q.mode == DRV_B) || (ctl_q.mode == DRV_ALL);
    assign sel_q = ctl_q.sel;

    AST_A_OE_ON: assert property (@(posedge clk) disable iff (rst)
        !a_drv_n |=> a_oe); // R9
    AST_A_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        a_drv_n |=> !a_oe); // R9
    AST_B_OE_ON: assert property (@(posedge clk) disable iff (rst)
        !b_drv_n |=> b_oe); // R9
    AST_B_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        b_drv_n |=> !b_oe); // R9
endmodule

// File: rtl/nwx_exchanger.sv
module nwx_exchanger #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b1_in,
    output logic [W-1:0] b1_out,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] b2_out,
    output logic         b_oe,
    input  logic         ld_1b_n,
    input  logic         ld_2b_n,
    input  logic         cap_1b_n,
    input  logic         cap_2b_n,
    input  logic         ret_sel,
    input  logic         a_drv_n,
    input  logic         b_drv_n
);
    localparam int LANES = 2;

    logic                    sel_q;
    logic [LANES-1:0][W-1:0] ret_q;

    nwx_oe_ctrl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .a_drv_n (a_drv_n),
        .b_drv_n (b_drv_n),
        .ret_sel (ret_sel),
        .a_oe    (a_oe),
        .b_oe    (b_oe),
        .sel_q   (sel_q)
    );

    nwx_a2b_path #(.W(W)) u_a2b (
        .clk     (clk),
        .rst     (rst),
        .blk     (a_oe),
        .ld_1b_n (ld_1b_n),
        .ld_2b_n (ld_2b_n),
        .a_in    (a_in),
        .b1_out  (b1_out),
        .b2_out  (b2_out)
    );

    nwx_b2a_path #(.W(W), .LANES(LANES)) u_b2a (
        .clk   (clk),
        .rst   (rst),
        .blk   (b_oe),
        .cap_n ({cap_2b_n, cap_1b_n}),
        .b_in  ({b2_in, b1_in}),
        .ret_q (ret_q)
    );

    assign a_out = sel_q ? ret_q[0] : ret_q[1];

    AST_A_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        a_oe |=> ($stable(b1_out) && $stable(b2_out))); // R10
    AST_SEL_ONE: assert property (@(posedge clk) disable iff (rst)
        (ret_sel && cap_1b_n) |=> (a_out == $past(ret_q[0]))); // R8
    AST_SEL_TWO: assert property (@(posedge clk) disable iff (rst)
        (!ret_sel && cap_2b_n) |=> (a_out == $past(ret_q[1]))); // R8
endmodule

// File: tb/nwx_exchanger_tb.sv
module nwx_exchanger_tb;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b1_in, b2_in;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_oe, b_oe;
    logic         ld_1b_n, ld_2b_n, cap_1b_n, cap_2b_n, ret_sel, a_drv_n, b_drv_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5ns clk = ~clk;

    nwx_exchanger #(.W(W)) u_dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_out(b1_out),
        .b2_in(b2_in), .b2_out(b2_out), .b_oe(b_oe),
        .ld_1b_n(ld_1b_n), .ld_2b_n(ld_2b_n),
        .cap_1b_n(cap_1b_n), .cap_2b_n(cap_2b_n),
        .ret_sel(ret_sel), .a_drv_n(a_drv_n), .b_drv_n(b_drv_n)
    );

    // Requirement-level model, updated from the inputs at each edge
    logic [W-1:0] m_s1, m_s2, m_w, m_r1, m_r2;
    logic         m_sel, m_aoe, m_boe;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_w <= '0; m_r1 <= '0; m_r2 <= '0;
            m_sel <= 1'b0; m_aoe <= 1'b0; m_boe <= 1'b0;
        end else begin
            if (!m_aoe) begin
                if (!ld_1b_n) m_s1 <= a_in;
                if (!ld_2b_n) begin m_s2 <= m_s1; m_w <= a_in; end
            end
            if (!m_boe) begin
                if (!cap_1b_n) m_r1 <= b1_in;
                if (!cap_2b_n) m_r2 <= b2_in;
            end
            m_sel <= ret_sel;
            m_aoe <= !a_drv_n;
            m_boe <= !b_drv_n;
        end
    end

    function automatic logic [W-1:0] exp_a(input logic s, input logic [W-1:0] r1, input logic [W-1:0] r2);
        return s ? r1 : r2;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ld(input logic l1, input logic l2, input logic [W-1:0] d);
        ld_1b_n = l1; ld_2b_n = l2; a_in = d;
    endtask

    initial begin
        #(200000 * 10ns);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w0, w1, hold1, hold2;
        rst = 1'b1; a_in = '0; b1_in = '0; b2_in = '0;
        ld_1b_n = 1'b1; ld_2b_n = 1'b1; cap_1b_n = 1'b1; cap_2b_n = 1'b1;
        ret_sel = 1'b0; a_drv_n = 1'b0; b_drv_n = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        // R1: reset state
        chk("R1 b1_out", b1_out, '0);
        chk("R1 b2_out", b2_out, '0);
        chk("R1 a_out", a_out, '0);
        chk("R1 a_oe", {11'b0, a_oe}, '0);
        chk("R1 b_oe", {11'b0, b_oe}, '0);

        a_drv_n = 1'b1; b_drv_n = 1'b0; step();
        chk("R9 b_oe only-B", {11'b0, b_oe}, 12'd1);
        chk("R9 a_oe only-B", {11'b0, a_oe}, 12'd0);

        set_ld(1'b0, 1'b1, 12'h111); step();
        chk("R2 b1 hold", b1_out, 12'h000);
        chk("R2 b2 hold", b2_out, 12'h000);
        set_ld(1'b1, 1'b0, 12'h222); step();
        chk("R3 b1 from stage1", b1_out, 12'h111);
        chk("R3 b2 load", b2_out, 12'h222);
        set_ld(1'b1, 1'b1, 12'hFFF); step(); step();
        chk("R5 b1 hold", b1_out, 12'h111);
        chk("R5 b2 hold", b2_out, 12'h222);
        set_ld(1'b0, 1'b0, 12'h333); step();
        chk("R4 b2 one edge", b2_out, 12'h333);
        chk("R4 b1 old stage1", b1_out, 12'h111);
        set_ld(1'b0, 1'b0, 12'h444); step();
        chk("R4 b1 two edges", b1_out, 12'h333);
        chk("R4 b2", b2_out, 12'h444);

        for (int k = 0; k < 20; k++) begin
            w0 = W'($urandom(32'h1234 + k));
            w1 = W'($urandom());
            set_ld(1'b0, 1'b1, w0); step();
            set_ld(1'b1, 1'b0, w1); step();
            chk("R6 pair 1B", b1_out, w0);
            chk("R6 pair 2B", b2_out, w1);
        end
        hold1 = b1_out; hold2 = b2_out;

        // R10: A driving blocks narrow-to-wide capture
        set_ld(1'b1, 1'b1, 12'h000); a_drv_n = 1'b0; step();
        set_ld(1'b0, 1'b0, 12'hABC); step(); step();
        chk("R10 A blocked b1", b1_out, hold1);
        chk("R10 A blocked b2", b2_out, hold2);
        set_ld(1'b1, 1'b1, 12'h000);

        // Return path
        b_drv_n = 1'b1; step();
        cap_1b_n = 1'b0; cap_2b_n = 1'b0; b1_in = 12'h5A5; b2_in = 12'h3C3; ret_sel = 1'b1; step();
        chk("R8 sel=1 picks 1B", a_out, 12'h5A5);
        cap_1b_n = 1'b1; cap_2b_n = 1'b1; b1_in = 12'h000; b2_in = 12'h000; ret_sel = 1'b0; step();
        chk("R8 sel=0 picks 2B", a_out, 12'h3C3);
        cap_1b_n = 1'b0; b1_in = 12'h111; b2_in = 12'h222; step();
        chk("R7 2B reg holds", a_out, 12'h3C3);
        cap_1b_n = 1'b1; ret_sel = 1'b1; step();
        chk("R7 1B reg captured", a_out, 12'h111);
        b_drv_n = 1'b0; step();
        cap_1b_n = 1'b0; cap_2b_n = 1'b0; b1_in = 12'hEEE; b2_in = 12'hDDD; step(); step();
        chk("R10 B blocked 1B", a_out, 12'h111);
        ret_sel = 1'b0; step();
        chk("R10 B blocked 2B", a_out, 12'h3C3);
        cap_1b_n = 1'b1; cap_2b_n = 1'b1;

        a_drv_n = 1'b1; b_drv_n = 1'b1; step();
        chk("R9 none a_oe", {11'b0, a_oe}, 12'd0);
        chk("R9 none b_oe", {11'b0, b_oe}, 12'd0);
        a_drv_n = 1'b0; b_drv_n = 1'b0; step();
        chk("R9 all a_oe", {11'b0, a_oe}, 12'd1);
        chk("R9 all b_oe", {11'b0, b_oe}, 12'd1);

        // Constrained random, checked against the model
        for (int c = 0; c < 3000; c++) begin
            chk("R3 rand b2_out", b2_out, m_w);
            chk("R4 rand b1_out", b1_out, m_s2);
            chk("R8 rand a_out", a_out, exp_a(m_sel, m_r1, m_r2));
            chk("R9 rand oe", {10'b0, a_oe, b_oe}, {10'b0, m_aoe, m_boe});
            a_in = W'($urandom()); b1_in = W'($urandom()); b2_in = W'($urandom());
            {ld_1b_n, ld_2b_n, cap_1b_n, cap_2b_n, ret_sel} = 5'($urandom());
            a_drv_n = ($urandom() % 4) != 0;
            b_drv_n = ($urandom() % 4) != 0;
            step();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule